// File: doc/BRIEF.md
# Rate-Adaptive Calibration Pulse Shaper

This block sits after an energy-to-frequency divider. Each time the divider has counted one quantum of energy, it raises a one-cycle request strobe. The shaper turns that strobe stream into an active-high pulse line for meter calibration. The shape of the pulse depends on how fast the pulses arrive.

When strobes are close together (a rate above roughly 5.55 Hz, so a period under roughly 180 ms), each pulse stays high for half of the most recently measured strobe interval. A steady stream then shows a 50% duty cycle. When strobes are sparse, each pulse is high for a fixed 90 ms. This keeps slow pulses wide enough for a counting instrument to see. The first strobe after reset has no earlier strobe to measure against, so it is shaped as slow.

Both the fixed width and the period threshold are tick counts, derived from the clock frequency by default. The block measures the interval between strobes in clock edges and saturates that count at the threshold. A status output shows when the 50% mode is in force. A strobe that arrives during a pulse is never lost: the running pulse is cut short, one low cycle follows, and then the new pulse is issued.

Top module: `cf_pulse_shaper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pulse_o` and `fast_o` are low.
- R2: A strobe sampled at a clock edge while `pulse_o` is low makes `pulse_o` high in the cycle that follows that edge.
- R3: The first strobe after reset produces a pulse that is exactly WIDTH_TICKS cycles high.
- R4: A strobe whose interval since the previous strobe is PERIOD_THRESH edges or more (equality included) produces a pulse exactly WIDTH_TICKS cycles high.
- R5: A strobe whose interval is below PERIOD_THRESH produces a pulse high for floor(interval/2) cycles, and never for less than one cycle.
- R6: A strobe sampled while `pulse_o` is high ends that pulse at once. `pulse_o` is then low for exactly one cycle, after which the new pulse runs for its full length.
- R7: A strobe sampled during that one-cycle gap replaces the waiting pulse. The replacement starts in the next cycle and uses the length computed for the newest strobe.
- R8: `fast_o` goes high in the cycle after a strobe that selects 50% mode. It stays high until a strobe selects the fixed width, or until PERIOD_THRESH edges pass with no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strb_i | input | 1 | One-cycle request for one output pulse |
| pulse_o | output | 1 | Shaped calibration pulse, active high |
| fast_o | output | 1 | High while 50% duty shaping is in use |

## Verification
On every cycle, the assertions check four things: a strobe on a low line raises it in the next cycle; a strobe on a high line forces a single low cycle and then a rise; no high run is longer than the longest legal pulse; and the mode flag rises only right after a strobe. The exact pulse lengths cannot be checked cycle by cycle. Halving of odd intervals, the boundary where an interval equal to the threshold still counts as slow, replacement of a waiting pulse during the gap, and the mode flag dropping after an idle spell all need the bench's reference model. That model is driven by scenarios with chosen strobe spacings.

// File: rtl/cf_pulse_shaper.sv
module cf_pulse_shaper #(
  parameter int unsigned CLK_HZ        = 200_000_000,
  parameter int unsigned WIDTH_MS      = 90,
  parameter int unsigned WIDTH_TICKS   = CLK_HZ / 1000 * WIDTH_MS,
  parameter int unsigned PERIOD_THRESH = 2 * WIDTH_TICKS
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_i,
  output logic pulse_o,
  output logic fast_o
);

  localparam int unsigned HALF_MAX = PERIOD_THRESH / 2;
  localparam int unsigned HI_MAX   = (WIDTH_TICKS > HALF_MAX) ? WIDTH_TICKS : HALF_MAX;
  localparam int unsigned IW       = $clog2(PERIOD_THRESH + 1);
  localparam int unsigned HW       = $clog2(HI_MAX + 1);

  logic [IW-1:0] since_q;
  logic [HW-1:0] hi_q, pend_len_q;
  logic          pend_q, fast_q;

  logic          short_ivl;
  logic [HW-1:0] half_len, new_len;

  assign short_ivl = since_q < IW'(PERIOD_THRESH);
  assign half_len  = HW'(since_q >> 1);
  assign new_len   = short_ivl ? ((half_len == '0) ? HW'(1) : half_len) : HW'(WIDTH_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q    <= IW'(PERIOD_THRESH);
      hi_q       <= '0;
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      fast_q     <= 1'b0;
    end else if (strb_i) begin
      since_q <= IW'(1);
      fast_q  <= short_ivl;
      if (hi_q != '0) begin
        hi_q       <= '0;
        pend_q     <= 1'b1;
        pend_len_q <= new_len;
      end else begin
        hi_q   <= new_len;
        pend_q <= 1'b0;
      end
    end else begin
      if (short_ivl) since_q <= since_q + IW'(1);
      else           fast_q  <= 1'b0;
      if (pend_q) begin
        hi_q   <= pend_len_q;
        pend_q <= 1'b0;
      end else if (hi_q != '0) begin
        hi_q <= hi_q - HW'(1);
      end
    end
  end

  assign pulse_o = hi_q != '0;
  assign fast_o  = fast_q;

endmodule

// File: rtl/cf_pulse_shaper_chk.sv
module cf_pulse_shaper_chk #(
  parameter int unsigned WIDTH_TICKS   = 16,
  parameter int unsigned PERIOD_THRESH = 32
) (
  input logic clk,
  input logic rst,
  input logic strb_i,
  input logic pulse_o,
  input logic fast_o
);
  localparam int unsigned HALF_MAX = PERIOD_THRESH / 2;
  localparam int unsigned HI_MAX   = (WIDTH_TICKS > HALF_MAX) ? WIDTH_TICKS : HALF_MAX;
  localparam int unsigned RW       = $clog2(HI_MAX + 2);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !pulse_o) run_q <= '0;
    else if (run_q <= RW'(HI_MAX)) run_q <= run_q + RW'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pulse_o && !fast_o));

  assert_strobe_rises_R2: assert property (@(posedge clk) disable iff (rst)
    (strb_i && !pulse_o) |=> pulse_o);

  assert_high_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(HI_MAX));

  assert_collision_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (strb_i && pulse_o) |=> !pulse_o ##1 pulse_o);

  assert_mode_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fast_o) |-> $past(strb_i));
endmodule

bind cf_pulse_shaper cf_pulse_shaper_chk #(
  .WIDTH_TICKS(WIDTH_TICKS),
  .PERIOD_THRESH(PERIOD_THRESH)
) u_chk (.*);

// File: tb/cf_pulse_shaper_bench.sv
`timescale 1ns/1ps
module cf_pulse_shaper_bench;
  localparam int W = 12;
  localparam int T = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strb = 1'b0;
  logic pulse, fast;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit started = 0;

  always #2.5 clk = ~clk;

  cf_pulse_shaper #(.WIDTH_TICKS(W), .PERIOD_THRESH(T)) u_cf_pulse_shaper (
    .clk(clk), .rst(rst), .strb_i(strb), .pulse_o(pulse), .fast_o(fast));

  // Reference model in terms of cycle timestamps
  longint cyc = 0, s_cyc = 0, e_cyc = 0, last = 0;
  bit have_last = 0, last_fast = 0;

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      s_cyc = 0; e_cyc = 0; have_last = 0; last_fast = 0;
    end else if (strb) begin
      longint ivl, len;
      bit hi_prev;
      ivl = have_last ? cyc - last : longint'(T);
      last_fast = ivl < T;
      len = last_fast ? ((ivl / 2 < 1) ? 1 : ivl / 2) : W;
      hi_prev = (cyc - 1 >= s_cyc) && (cyc - 1 < e_cyc);
      s_cyc = hi_prev ? cyc + 1 : cyc;
      e_cyc = s_cyc + len;
      last = cyc;
      have_last = 1;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      check(tag, pulse, (cyc >= s_cyc) && (cyc < e_cyc));
      check("R8", fast, have_last && last_fast && (cyc - last < T));
    end
  end

  task automatic strobes(int count, int ivl);
    for (int c = 0; c < count * ivl; c++) begin
      @(negedge clk);
      strb = (c % ivl == 0);
    end
    @(negedge clk);
    strb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(4);
    check("R1", pulse, 1'b0);
    check("R1", fast, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", pulse, 1'b0);
    check("R1", fast, 1'b0);
    idle(3);

    tag = "R3";
    @(negedge clk); strb = 1'b1;
    @(negedge clk); strb = 1'b0;
    check("R2", pulse, 1'b1);
    idle(40);

    tag = "R4";
    strobes(3, 30);
    strobes(3, T);
    idle(40);

    tag = "R5";
    strobes(5, 10);
    strobes(4, T - 1);
    strobes(5, 7);
    strobes(4, 3);
    strobes(6, 1);
    idle(40);

    tag = "R6";
    @(negedge clk); strb = 1'b1;
    @(negedge clk); strb = 1'b0;
    idle(4);
    @(negedge clk); strb = 1'b1;
    @(negedge clk); strb = 1'b0;
    idle(40);
    strobes(3, 2);
    idle(40);

    tag = "R7";
    @(negedge clk); strb = 1'b1;
    @(negedge clk); strb = 1'b1;
    @(negedge clk); strb = 1'b1;
    @(negedge clk); strb = 1'b0;
    idle(40);

    tag = "R8";
    strobes(4, 8);
    idle(T + 10);
    check("R8", fast, 1'b0);
    strobes(2, 30);
    idle(40);

    finish_run();
  end
endmodule